// File: doc/BRIEF.md
# Hypervisor Trap Router

This block chooses the handler level for every trap in a core that runs a hypervisor above a guest kernel. Each cycle it may receive one synchronous exception (6-bit cause plus a trap value) and one interrupt request (6-bit number). It also receives the privilege mode the core is in and the program counter of the instruction concerned. It arbitrates between the two requests and picks the target level. It then captures the trap record in registered outputs: target mode, cause word, faulting PC, trap value and the PC at which the interrupted code resumes.

Traps raised by guest code go to the hypervisor unless the hypervisor has delegated that cause back to the guest kernel. Two delegation masks decide this, one for exceptions and one for interrupts, each with one bit per cause. A single write port loads the masks. The router keeps a separate saved context (previous mode and resume PC) for each handler level, so a guest-kernel trap can be interrupted by a hypervisor trap. A return request names the level that is returning and gets back that level's saved context.

Mode encoding on all mode ports: 0 = native (non-virtualized user/machine), 1 = guest user, 2 = guest kernel, 3 = hypervisor.

Top module: `trap_router`

## Requirements
- R1: After reset every output is zero and both delegation masks are zero, so a guest trap right after reset goes to mode 3.
- R2: A trap taken in mode 1 or 2 whose cause bit is clear in the matching mask goes to mode 3.
- R3: A trap taken in mode 3 or mode 0 always goes to mode 3, whatever the masks hold.
- R4: A trap taken in mode 1 or 2 whose cause bit is set goes to mode 2. Exceptions look up the exception mask and interrupts look up the interrupt mask, independently.
- R5: The cause word has bit 63 set for an interrupt and clear for an exception, the 6-bit code in bits 5:0, and zeros elsewhere. The trap value output holds the supplied value for exceptions and zero for interrupts.
- R6: When an exception and an interrupt arrive in the same cycle, the exception is recorded and the interrupt is dropped for that cycle.
- R7: The resume PC is the faulting PC plus 4 for exceptions and equals the faulting PC for interrupts.
- R8: A return request with level select 1 (hypervisor) or 0 (guest kernel) produces a one-cycle return pulse. It reports the mode and resume PC saved by the last trap into that level. The two levels keep separate contexts.
- R9: A return request in the same cycle as a trap is ignored: no return pulse, and the trap is recorded.
- R10: A mask write (select 0 = exception mask, 1 = interrupt mask) replaces the whole mask at the clock edge. It governs traps from the next cycle on, and a trap in the write cycle uses the old mask.
- R11: All results appear on the cycle after the inputs are sampled. The trap pulse lasts one cycle, and the record outputs hold until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_we_i | input | 1 | Delegation mask write strobe |
| mask_sel_i | input | 1 | 0 selects exception mask, 1 interrupt mask |
| mask_wdata_i | input | 64 | New mask value |
| mode_i | input | 2 | Current privilege mode |
| pc_i | input | 64 | PC of the trapping instruction |
| exc_valid_i | input | 1 | Exception request |
| exc_code_i | input | 6 | Exception cause |
| exc_tval_i | input | 64 | Exception trap value |
| irq_valid_i | input | 1 | Interrupt request |
| irq_code_i | input | 6 | Interrupt number |
| ret_i | input | 1 | Return-from-trap request |
| ret_lvl_i | input | 1 | Returning level: 1 hypervisor, 0 guest kernel |
| trap_o | output | 1 | Trap taken pulse |
| tgt_mode_o | output | 2 | Target mode of the last trap |
| cause_o | output | 64 | Cause word of the last trap |
| epc_o | output | 64 | Faulting PC of the last trap |
| tval_o | output | 64 | Trap value of the last trap |
| resume_o | output | 64 | Resume PC of the last trap |
| ret_o | output | 1 | Return taken pulse |
| ret_mode_o | output | 2 | Mode restored by the return |
| ret_pc_o | output | 64 | PC restored by the return |

## Verification
A stale or corrupted delegation mask shows up as a wrong target mode on the first guest trap that uses the affected cause. That is one cycle after the trap, since the record outputs are registered. A broken arbitration or record path gives a wrong cause flag, trap value or resume PC on the cycle after the trap. A fault in the per-level saved context stays hidden until the matching return. Only then do the restored mode and PC show the fault, so the bench nests traps before it returns. A return that slips through beside a trap shows as a stray return pulse.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    MODE_NAT = 2'd0,
    MODE_VU  = 2'd1,
    MODE_VS  = 2'd2,
    MODE_HS  = 2'd3
  } priv_e;
endpackage

// File: rtl/trap_deleg_regs.sv
module trap_deleg_regs #(
  parameter int NCAUSE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [NCAUSE-1:0] wdata_i,
  output logic [NCAUSE-1:0] exc_mask_o,
  output logic [NCAUSE-1:0] irq_mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_mask_o <= '0;
      irq_mask_o <= '0;
    end else if (we_i) begin
      if (sel_i) irq_mask_o <= wdata_i;
      else       exc_mask_o <= wdata_i;
    end
  end

  // R10: masks change only through the write port
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> ($stable(exc_mask_o) && $stable(irq_mask_o)));
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int NCAUSE = 64,
  localparam int CW = $clog2(NCAUSE)
) (
  input  priv_e             mode_i,
  input  logic              exc_valid_i,
  input  logic [CW-1:0]     exc_code_i,
  input  logic              irq_valid_i,
  input  logic [CW-1:0]     irq_code_i,
  input  logic [NCAUSE-1:0] exc_mask_i,
  input  logic [NCAUSE-1:0] irq_mask_i,
  output logic              go_o,
  output logic              is_irq_o,
  output logic [CW-1:0]     code_o,
  output logic              to_vs_o
);
  logic guest, deleg;

  always_comb begin
    go_o     = exc_valid_i | irq_valid_i;
    is_irq_o = irq_valid_i & ~exc_valid_i;
    code_o   = exc_valid_i ? exc_code_i : irq_code_i;
    guest    = (mode_i == MODE_VU) || (mode_i == MODE_VS);
    deleg    = is_irq_o ? irq_mask_i[code_o] : exc_mask_i[code_o];
    to_vs_o  = go_o & guest & deleg;
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_i,
  input  logic [1:0]      mode_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [1:0]      mode_o,
  output logic [XLEN-1:0] pc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= '0;
      pc_o   <= '0;
    end else if (cap_i) begin
      mode_o <= mode_i;
      pc_o   <= pc_i;
    end
  end

  // R8: a level's saved context survives traps into the other level
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> ($stable(mode_o) && $stable(pc_o)));
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NCAUSE = 64,
  localparam int CW    = $clog2(NCAUSE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we_i,
  input  logic              mask_sel_i,
  input  logic [NCAUSE-1:0] mask_wdata_i,
  input  logic [1:0]        mode_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              exc_valid_i,
  input  logic [CW-1:0]     exc_code_i,
  input  logic [XLEN-1:0]   exc_tval_i,
  input  logic              irq_valid_i,
  input  logic [CW-1:0]     irq_code_i,
  input  logic              ret_i,
  input  logic              ret_lvl_i,
  output logic              trap_o,
  output logic [1:0]        tgt_mode_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic [XLEN-1:0]   tval_o,
  output logic [XLEN-1:0]   resume_o,
  output logic              ret_o,
  output logic [1:0]        ret_mode_o,
  output logic [XLEN-1:0]   ret_pc_o
);
  localparam int NLVL = 2;  // bank 0: guest kernel, bank 1: hypervisor

  logic [NCAUSE-1:0] exc_mask, irq_mask;
  logic              go, is_irq, to_vs;
  logic [CW-1:0]     code;
  logic [XLEN-1:0]   resume_nxt;
  logic [XLEN-1:0]   cause_nxt;
  logic [1:0]        bank_mode [NLVL];
  logic [XLEN-1:0]   bank_pc   [NLVL];

  trap_deleg_regs #(.NCAUSE(NCAUSE)) u_regs (
    .clk(clk), .rst(rst), .we_i(mask_we_i), .sel_i(mask_sel_i),
    .wdata_i(mask_wdata_i), .exc_mask_o(exc_mask), .irq_mask_o(irq_mask)
  );

  trap_route #(.NCAUSE(NCAUSE)) u_route (
    .mode_i(priv_e'(mode_i)), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .irq_valid_i(irq_valid_i), .irq_code_i(irq_code_i),
    .exc_mask_i(exc_mask), .irq_mask_i(irq_mask),
    .go_o(go), .is_irq_o(is_irq), .code_o(code), .to_vs_o(to_vs)
  );

  always_comb begin
    resume_nxt = is_irq ? pc_i : pc_i + XLEN'(4);
    cause_nxt  = {is_irq, {(XLEN-1-CW){1'b0}}, code};
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_bank
    trap_bank #(.XLEN(XLEN)) u_bank (
      .clk(clk), .rst(rst),
      .cap_i(go && (to_vs == (g == 0))),
      .mode_i(mode_i), .pc_i(resume_nxt),
      .mode_o(bank_mode[g]), .pc_o(bank_pc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o     <= 1'b0;
      tgt_mode_o <= '0;
      cause_o    <= '0;
      epc_o      <= '0;
      tval_o     <= '0;
      resume_o   <= '0;
      ret_o      <= 1'b0;
      ret_mode_o <= '0;
      ret_pc_o   <= '0;
    end else begin
      trap_o <= go;
      ret_o  <= ret_i & ~go;
      if (go) begin
        tgt_mode_o <= to_vs ? MODE_VS : MODE_HS;
        cause_o    <= cause_nxt;
        epc_o      <= pc_i;
        tval_o     <= is_irq ? '0 : exc_tval_i;
        resume_o   <= resume_nxt;
      end else if (ret_i) begin
        ret_mode_o <= bank_mode[ret_lvl_i];
        ret_pc_o   <= bank_pc[ret_lvl_i];
      end
    end
  end

  // R3: hypervisor and native traps never land in the guest kernel
  p_hs_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (go && (mode_i == MODE_HS || mode_i == MODE_NAT)) |=> (tgt_mode_o == MODE_HS));
  // R4: only guest-mode traps can be delegated
  p_vs_from_guest_r4: assert property (@(posedge clk) disable iff (rst)
    to_vs |-> (mode_i == MODE_VU || mode_i == MODE_VS));
  // R6: a pending exception always beats an interrupt
  p_exc_first_r6: assert property (@(posedge clk) disable iff (rst)
    exc_valid_i |=> (trap_o && !cause_o[XLEN-1]));
  // R7: exception records resume one instruction later
  p_resume_r7: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !cause_o[XLEN-1]) |-> (resume_o == epc_o + XLEN'(4)));
  // R9: a return beside a trap is dropped
  p_trap_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (go && ret_i) |=> !ret_o);
  // R11: trap and return pulses never overlap
  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_o, ret_o}));
endmodule

// File: tb/tb_trap_router.sv
module tb_trap_router;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mask_we = 0, mask_sel = 0;
  logic [63:0] mask_wdata = '0;
  logic [1:0] mode = '0;
  logic [63:0] pc = '0, tval_in = '0;
  logic ev = 0, iv = 0, ret = 0, ret_lvl = 0;
  logic [5:0] ec = '0, ic = '0;
  logic trap_o, ret_o;
  logic [1:0] tgt_mode_o, ret_mode_o;
  logic [63:0] cause_o, epc_o, tval_o, resume_o, ret_pc_o;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_router dut (
    .clk(clk), .rst(rst), .mask_we_i(mask_we), .mask_sel_i(mask_sel),
    .mask_wdata_i(mask_wdata), .mode_i(mode), .pc_i(pc),
    .exc_valid_i(ev), .exc_code_i(ec), .exc_tval_i(tval_in),
    .irq_valid_i(iv), .irq_code_i(ic), .ret_i(ret), .ret_lvl_i(ret_lvl),
    .trap_o(trap_o), .tgt_mode_o(tgt_mode_o), .cause_o(cause_o),
    .epc_o(epc_o), .tval_o(tval_o), .resume_o(resume_o),
    .ret_o(ret_o), .ret_mode_o(ret_mode_o), .ret_pc_o(ret_pc_o)
  );

  // vector: mode[17:16] ev[15] ec[14:9] iv[8] ic[7:2] expected target[1:0]
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {2'd1, 1'b1, 6'd2,  1'b0, 6'd0, 2'd2},  // R4 guest user, delegated exc
    {2'd1, 1'b1, 6'd3,  1'b0, 6'd0, 2'd3},  // R2 not delegated
    {2'd2, 1'b1, 6'd13, 1'b0, 6'd0, 2'd2},  // R4 guest kernel, delegated
    {2'd2, 1'b0, 6'd0,  1'b1, 6'd5, 2'd2},  // R4 delegated interrupt
    {2'd2, 1'b0, 6'd0,  1'b1, 6'd2, 2'd3},  // R4 irq mask separate from exc
    {2'd1, 1'b1, 6'd5,  1'b0, 6'd0, 2'd3},  // R4 exc mask separate from irq
    {2'd3, 1'b1, 6'd2,  1'b0, 6'd0, 2'd3},  // R3 hypervisor ignores mask
    {2'd3, 1'b0, 6'd0,  1'b1, 6'd5, 2'd3},  // R3
    {2'd0, 1'b1, 6'd13, 1'b0, 6'd0, 2'd3},  // R3 native mode
    {2'd2, 1'b1, 6'd3,  1'b1, 6'd5, 2'd3},  // R6 exc wins
    {2'd1, 1'b1, 6'd2,  1'b1, 6'd5, 2'd2},  // R6 exc wins, delegated
    {2'd1, 1'b1, 6'd63, 1'b0, 6'd0, 2'd2}   // R4 top cause bit
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; inputs sampled at the next posedge, returns at the negedge after it
  task automatic do_trap(input logic [1:0] m, input logic e, input logic [5:0] ecode,
                         input logic i, input logic [5:0] icode,
                         input logic [63:0] p, input logic [63:0] tv);
    mode = m; ev = e; ec = ecode; iv = i; ic = icode; pc = p; tval_in = tv;
    @(negedge clk);
    ev = 0; iv = 0;
  endtask

  task automatic write_mask(input logic sel, input logic [63:0] val);
    mask_we = 1; mask_sel = sel; mask_wdata = val;
    @(negedge clk);
    mask_we = 0;
  endtask

  task automatic do_ret(input logic lvl);
    ret = 1; ret_lvl = lvl;
    @(negedge clk);
    ret = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(!trap_o && !ret_o && tgt_mode_o == 0 && cause_o == 0 && resume_o == 0
        && epc_o == 0 && tval_o == 0 && ret_pc_o == 0 && ret_mode_o == 0,
        "R1 reset outputs", cause_o, 0);
    do_trap(2'd1, 1, 6'd2, 0, 6'd0, 64'h500, 64'h7);
    chk(tgt_mode_o == 2'd3, "R1 masks clear after reset", tgt_mode_o, 3);

    write_mask(0, (64'd1 << 2) | (64'd1 << 13) | (64'd1 << 63));
    write_mask(1, 64'd1 << 5);

    for (int k = 0; k < NV; k++) begin
      logic [63:0] p, tv, ecause, etval, eres;
      logic isirq;
      p  = 64'h1000 + 64'(k) * 16;
      tv = 64'hBEEF_0000 + 64'(k);
      isirq = VEC[k][8] && !VEC[k][15];
      do_trap(VEC[k][17:16], VEC[k][15], VEC[k][14:9], VEC[k][8], VEC[k][7:2], p, tv);
      ecause = isirq ? {1'b1, 57'd0, VEC[k][7:2]} : {58'd0, VEC[k][14:9]};
      etval  = isirq ? 64'd0 : tv;
      eres   = isirq ? p : p + 4;
      chk(trap_o && tgt_mode_o == VEC[k][1:0], "R2/R3/R4 target", tgt_mode_o, VEC[k][1:0]);
      chk(cause_o == ecause && tval_o == etval, "R5/R6 cause and tval", cause_o, ecause);
      chk(epc_o == p && resume_o == eres, "R7 resume pc", resume_o, eres);
    end

    // R11 pulse length and hold
    @(negedge clk);
    chk(!trap_o && cause_o == 64'd63 && tgt_mode_o == 2'd2, "R11 pulse ends, record holds",
        {trap_o, cause_o[62:0]}, 64'd63);

    // R8 nested contexts
    do_trap(2'd1, 1, 6'd2, 0, 6'd0, 64'h2000, 64'h1);   // to guest kernel, saves mode 1
    do_trap(2'd2, 1, 6'd3, 0, 6'd0, 64'h3000, 64'h2);   // to hypervisor, saves mode 2
    chk(tgt_mode_o == 2'd3, "R8 nested trap target", tgt_mode_o, 3);
    do_ret(1);
    chk(ret_o && ret_mode_o == 2'd2 && ret_pc_o == 64'h3004, "R8 return from hypervisor",
        ret_pc_o, 64'h3004);
    do_ret(0);
    chk(ret_o && ret_mode_o == 2'd1 && ret_pc_o == 64'h2004, "R8 return from guest kernel",
        ret_pc_o, 64'h2004);
    @(negedge clk);
    chk(!ret_o, "R8 return pulse one cycle", ret_o, 0);

    // R9 trap and return together
    ret = 1; ret_lvl = 1;
    do_trap(2'd3, 0, 6'd0, 1, 6'd7, 64'h4000, 64'h0);
    ret = 0;
    chk(trap_o && !ret_o && ret_pc_o == 64'h2004, "R9 return ignored beside trap",
        {ret_o, ret_pc_o[62:0]}, 64'h2004);
    chk(resume_o == 64'h4000 && cause_o[63], "R7 interrupt resumes at same pc", resume_o, 64'h4000);

    // R10 write timing: trap in write cycle uses old mask
    mask_we = 1; mask_sel = 0; mask_wdata = 64'd1 << 3;
    do_trap(2'd1, 1, 6'd3, 0, 6'd0, 64'h5000, 64'h0);
    mask_we = 0;
    chk(tgt_mode_o == 2'd3, "R10 old mask in write cycle", tgt_mode_o, 3);
    do_trap(2'd1, 1, 6'd3, 0, 6'd0, 64'h5100, 64'h0);
    chk(tgt_mode_o == 2'd2, "R10 new mask next cycle", tgt_mode_o, 2);
    do_trap(2'd1, 1, 6'd2, 0, 6'd0, 64'h5200, 64'h0);
    chk(tgt_mode_o == 2'd3, "R10 write replaces whole mask", tgt_mode_o, 3);
    do_trap(2'd2, 0, 6'd0, 1, 6'd5, 64'h5300, 64'h0);
    chk(tgt_mode_o == 2'd2, "R10 interrupt mask untouched", tgt_mode_o, 2);

    // R3 with every cause delegated
    write_mask(0, '1);
    do_trap(2'd3, 1, 6'd9, 0, 6'd0, 64'h6000, 64'h3);
    chk(tgt_mode_o == 2'd3, "R3 hypervisor ignores full mask", tgt_mode_o, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule